// File: doc/BRIEF.md
# Two-Wire Synchronous Command and Data Link

This block connects a controller to instrument boards over a clocked serial link of two wires: a link clock and a data line. On the outgoing side it takes a command (an 8-bit address and 16 bits of command data) on a valid/ready handshake. It produces a free-running link clock divided from the system clock, and shifts out a framed command word on the data line. The frame is a start bit, 24 payload bits, an odd parity bit and a stop bit.

On the incoming side it watches a link clock and data line driven by a board. Both wires are brought into the system clock domain through synchronizers, and the data is sampled on each rising link clock. A format input selects one of two word shapes: a short word of 16 bits preceded only by a start bit, or a long word of 24 bits framed with start, parity and stop. Each received word is presented in parallel with a one-cycle valid strobe and with parity-error and framing-error flags.

Top module: `sclink_core`

## Requirements
- R1: While `rst_n` is low and directly after it, `tx_ldat` is 1, `tx_lclk` is 0, `cmd_ready` is 1 and `rx_valid` is 0.
- R2: `tx_lclk` toggles continuously, each level lasting exactly HALF_DIV system cycles, so one link period is 2*HALF_DIV cycles.
- R3: `tx_ldat` changes only in a cycle where `tx_lclk` falls, and sits at 1 whenever no frame is being sent.
- R4: An outgoing frame is 27 bits, each held for one link period: start bit 0, then `cmd_addr` MSB first, then `cmd_data` MSB first, then a parity bit chosen so that the 24 payload bits plus parity hold an odd number of ones, then stop bit 1.
- R5: A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the next cycle until the stop bit is on the line, and `cmd_valid` while `cmd_ready` is 0 starts no frame.
- R6: With `rx_fmt`=1 (long), a start bit 0 is followed by 24 data bits MSB first into `rx_word[23:0]`, a parity bit and a stop bit. The word is delivered once the stop bit is sampled.
- R7: With `rx_fmt`=0 (short), a start bit 0 is followed by 16 data bits MSB first into `rx_word[15:0]`, with `rx_word[23:16]`=0 and both error flags 0. No parity or stop bit follows, and the very next sampled bit may be a new start bit.
- R8: In a long word whose payload plus parity bit has an even count of ones, `rx_par_err` is 1 with the word delivered unchanged.
- R9: A long word whose stop bit is sampled as 0 is delivered with `rx_frm_err`=1. The receiver then takes no start bit until it has sampled a 1 on the data line.
- R10: `rx_valid` is a single-cycle pulse per received word. `rx_word` and the flags hold until the next delivery.
- R11: `rx_fmt` is taken only at the start bit; a change during a frame does not alter that frame's shape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_addr | input | 8 | Command address |
| cmd_data | input | 16 | Command data |
| cmd_ready | output | 1 | Transmitter idle, command can be taken |
| tx_lclk | output | 1 | Outgoing link clock |
| tx_ldat | output | 1 | Outgoing serial data, idles high |
| rx_lclk | input | 1 | Incoming link clock (asynchronous) |
| rx_ldat | input | 1 | Incoming serial data (asynchronous) |
| rx_fmt | input | 1 | Receive format: 1 long, 0 short |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_word | output | 24 | Received word, right-aligned |
| rx_par_err | output | 1 | Parity mismatch on the last word |
| rx_frm_err | output | 1 | Missing stop bit on the last word |

## Verification
The bound checker watches, on every cycle, the link clock cadence and that outgoing data only moves on a falling link clock. It also checks that `cmd_ready` drops after each acceptance, that `rx_valid` never lasts two cycles, and that a short word always arrives with a clear top byte and no error flags. The content of frames can only be shown by the bench's scenarios: the bit order and parity of sent commands, received words in both formats, injected parity and stop-bit faults, the idle hunt after a framing fault, back-to-back short words, and a format change in mid-frame.

// File: rtl/sclink_pkg.sv
package sclink_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HUNT
  } rx_state_t;
endpackage

// File: rtl/sclink_clkgen.sv
module sclink_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic lclk,
  output logic fall_evt
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = (cnt == LAST);
  assign fall_evt = wrap && lclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      lclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      lclk <= ~lclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sclink_tx.sv
module sclink_tx #(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_evt,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              cmd_ready,
  output logic              ldat
);
  localparam int PAY_W = ADDR_W + CMD_W;
  localparam int FRM_W = PAY_W + 3;
  localparam int BC_W  = $clog2(FRM_W + 1);

  function automatic logic [FRM_W-1:0] build_frame(input logic [ADDR_W-1:0] a,
                                                    input logic [CMD_W-1:0]  d);
    logic [PAY_W-1:0] pay;
    pay = {a, d};
    return {1'b0, pay, ~^pay, 1'b1};
  endfunction

  logic [FRM_W-1:0] shreg;
  logic [BC_W-1:0]  left;
  logic             accept;

  assign cmd_ready = (left == '0);
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
      ldat  <= 1'b1;
    end else if (accept) begin
      shreg <= build_frame(cmd_addr, cmd_data);
      left  <= BC_W'(FRM_W);
    end else if (fall_evt && (left != '0)) begin
      ldat  <= shreg[FRM_W-1];
      shreg <= {shreg[FRM_W-2:0], 1'b0};
      left  <= left - 1'b1;
    end
  end
endmodule

// File: rtl/sclink_sync.sv
module sclink_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= {STAGES{RST_VAL}};
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/sclink_rx.sv
module sclink_rx
  import sclink_pkg::*;
#(
  parameter int LONG_W  = 24,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_evt,
  input  logic              samp_bit,
  input  logic              fmt_long,
  output logic              rx_valid,
  output logic [LONG_W-1:0] rx_word,
  output logic              par_err,
  output logic              frm_err,
  output logic              long_q
);
  localparam int CNT_W = $clog2(LONG_W + 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);

  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [LONG_W-1:0] shreg;
  logic             perr_q;
  logic             last_data;
  logic [LONG_W-1:0] shifted;

  assign last_data = (cnt == (long_q ? LAST_LONG : LAST_SHORT));
  assign shifted   = {shreg[LONG_W-2:0], samp_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      perr_q   <= 1'b0;
      long_q   <= 1'b0;
      rx_valid <= 1'b0;
      rx_word  <= '0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (samp_evt) begin
        case (state)
          RX_IDLE: if (!samp_bit) begin
            long_q <= fmt_long;
            cnt    <= '0;
            shreg  <= '0;
            state  <= RX_DATA;
          end
          RX_DATA: begin
            shreg <= shifted;
            cnt   <= cnt + 1'b1;
            if (last_data) begin
              if (long_q) begin
                state <= RX_PAR;
              end else begin
                rx_word  <= shifted;
                par_err  <= 1'b0;
                frm_err  <= 1'b0;
                rx_valid <= 1'b1;
                state    <= RX_IDLE;
              end
            end
          end
          RX_PAR: begin
            perr_q <= ~(^{shreg, samp_bit});
            state  <= RX_STOP;
          end
          RX_STOP: begin
            rx_word  <= shreg;
            par_err  <= perr_q;
            frm_err  <= ~samp_bit;
            rx_valid <= 1'b1;
            state    <= samp_bit ? RX_IDLE : RX_HUNT;
          end
          RX_HUNT: if (samp_bit) state <= RX_IDLE;
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sclink_core.sv
module sclink_core #(
  parameter int HALF_DIV    = 4,
  parameter int ADDR_W      = 8,
  parameter int CMD_W       = 16,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [ADDR_W-1:0]         cmd_addr,
  input  logic [CMD_W-1:0]          cmd_data,
  output logic                      cmd_ready,
  output logic                      tx_lclk,
  output logic                      tx_ldat,
  input  logic                      rx_lclk,
  input  logic                      rx_ldat,
  input  logic                      rx_fmt,
  output logic                      rx_valid,
  output logic [ADDR_W+CMD_W-1:0]   rx_word,
  output logic                      rx_par_err,
  output logic                      rx_frm_err
);
  localparam int LONG_W = ADDR_W + CMD_W;

  logic fall_evt;
  logic s_lclk, s_ldat, lclk_prev, samp_evt;
  logic rx_long_q;

  sclink_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .lclk(tx_lclk), .fall_evt(fall_evt)
  );

  sclink_tx #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .ldat(tx_ldat)
  );

  sclink_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .din(rx_lclk), .dout(s_lclk)
  );

  sclink_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .din(rx_ldat), .dout(s_ldat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) lclk_prev <= 1'b0;
    else        lclk_prev <= s_lclk;
  end

  assign samp_evt = s_lclk && !lclk_prev;

  sclink_rx #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .samp_evt(samp_evt), .samp_bit(s_ldat),
    .fmt_long(rx_fmt), .rx_valid(rx_valid), .rx_word(rx_word),
    .par_err(rx_par_err), .frm_err(rx_frm_err), .long_q(rx_long_q)
  );
endmodule

// File: rtl/sclink_core_chk.sv
module sclink_core_chk #(
  parameter int HALF_DIV = 4,
  parameter int LONG_W   = 24,
  parameter int SHORT_W  = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tx_lclk,
  input logic                      tx_ldat,
  input logic                      cmd_valid,
  input logic                      cmd_ready,
  input logic                      rx_valid,
  input logic [LONG_W-SHORT_W-1:0] rx_word_hi,
  input logic                      rx_par_err,
  input logic                      rx_frm_err,
  input logic                      rx_long_q
);
  logic [15:0] gap;
  logic        lclk_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap       <= '0;
      lclk_prev <= 1'b0;
    end else begin
      lclk_prev <= tx_lclk;
      if (tx_lclk != lclk_prev) gap <= '0;
      else if (gap != 16'hFFFF) gap <= gap + 1'b1;
    end
  end

  // R2: no level of the link clock outlasts HALF_DIV cycles
  assert_lclk_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= 16'(HALF_DIV));

  // R2: no level of the link clock is shorter than HALF_DIV cycles
  assert_lclk_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lclk != lclk_prev) |-> gap >= 16'(HALF_DIV - 1));

  assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(tx_ldat) |-> $fell(tx_lclk));

  assert_ready_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_short_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_long_q) |-> (rx_word_hi == '0 && !rx_par_err && !rx_frm_err));

  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind sclink_core sclink_core_chk #(
  .HALF_DIV(HALF_DIV), .LONG_W(LONG_W), .SHORT_W(SHORT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_lclk(tx_lclk), .tx_ldat(tx_ldat),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .rx_valid(rx_valid),
  .rx_word_hi(rx_word[LONG_W-1:SHORT_W]), .rx_par_err(rx_par_err),
  .rx_frm_err(rx_frm_err), .rx_long_q(rx_long_q)
);

// File: tb/sclink_core_test.sv
`timescale 1ns/1ps
module sclink_core_test;
  localparam int HALF = 4;
  localparam int RXH  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic        cmd_ready, tx_lclk, tx_ldat;
  logic        rx_lclk = 1'b0;
  logic        rx_ldat = 1'b1;
  logic        rx_fmt = 1'b1;
  logic        rx_valid, rx_par_err, rx_frm_err;
  logic [23:0] rx_word;

  int nchk = 0;
  int nerr = 0;
  int got_cnt = 0;
  logic [23:0] got_word = '0;
  logic        got_pe = 1'b0, got_fe = 1'b0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  sclink_core #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_ready(cmd_ready), .tx_lclk(tx_lclk),
    .tx_ldat(tx_ldat), .rx_lclk(rx_lclk), .rx_ldat(rx_ldat), .rx_fmt(rx_fmt),
    .rx_valid(rx_valid), .rx_word(rx_word), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err)
  );

  // {fmt, bad_parity, stop_value, 0, word[23:0]}
  localparam logic [27:0] VEC [6] = '{
    28'hA_A5C30F, 28'hE_000001, 28'h8_FFFFFF,
    28'h2_12BEEF, 28'h2_008001, 28'hC_800000
  };

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      got_cnt  = got_cnt + 1;
      got_word = rx_word;
      got_pe   = rx_par_err;
      got_fe   = rx_frm_err;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rx_bit(input logic b);
    @(negedge clk);
    rx_ldat = b;
    repeat (RXH) @(negedge clk);
    rx_lclk = 1'b1;
    repeat (RXH) @(negedge clk);
    rx_lclk = 1'b0;
  endtask

  // odd parity bit for a 24-bit payload, worked from the ones count
  function automatic logic odd_bit(input logic [23:0] w);
    return ($countones(w) % 2) == 0;
  endfunction

  task automatic rx_frame(input logic fmt, input logic [23:0] w,
                          input logic bad_par, input logic stop, input bit flip);
    rx_fmt = fmt;
    rx_bit(1'b0);
    if (flip) rx_fmt = ~fmt;
    if (fmt) begin
      for (int i = 23; i >= 0; i--) rx_bit(w[i]);
      rx_bit(odd_bit(w) ^ bad_par);
      rx_bit(stop);
    end else begin
      for (int i = 15; i >= 0; i--) rx_bit(w[i]);
    end
  endtask

  task automatic tx_capture(output logic [26:0] frm, output bit ok);
    int n = 0;
    int guard = 0;
    logic prev;
    prev = tx_lclk;
    frm  = '0;
    while (n < 27 && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (tx_lclk && !prev && (n > 0 || tx_ldat == 1'b0)) begin
        frm = {frm[25:0], tx_ldat};
        n++;
      end
      prev = tx_lclk;
    end
    ok = (n == 27);
  endtask

  task automatic tx_case(input logic [7:0] a, input logic [15:0] d);
    logic [26:0] frm, exp;
    bit ok;
    int lows = 0;
    exp = {1'b0, a, d, odd_bit({a, d}), 1'b1};
    @(negedge clk);
    cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R5 ready low after accept", 32'(cmd_ready), 0);
    fork
      begin
        repeat (3) @(negedge clk);
        cmd_addr = 8'hEE; cmd_data = 16'h0BAD; cmd_valid = 1'b1;
        repeat (20) @(negedge clk);
        cmd_valid = 1'b0;
      end
      tx_capture(frm, ok);
    join
    check(ok && frm == exp, "R4 tx frame", 32'(frm), 32'(exp));
    check(cmd_ready == 1'b1, "R5 ready after stop", 32'(cmd_ready), 1);
    for (int i = 0; i < 6 * HALF; i++) begin
      @(negedge clk);
      if (!tx_ldat) lows++;
    end
    check(lows == 0, "R5 busy command ignored, R3 idle high", lows, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int c0, n, rise0, rise1;
    logic prev;
    logic [23:0] w, ew;
    logic pe, fe;

    repeat (3) @(negedge clk);
    // R1 during reset
    check(tx_ldat == 1'b1,  "R1 tx_ldat", 32'(tx_ldat), 1);
    check(tx_lclk == 1'b0,  "R1 tx_lclk", 32'(tx_lclk), 0);
    check(cmd_ready == 1'b1, "R1 cmd_ready", 32'(cmd_ready), 1);
    check(rx_valid == 1'b0, "R1 rx_valid", 32'(rx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_ldat == 1'b1 && cmd_ready == 1'b1, "R1 after release",
          32'({tx_ldat, cmd_ready}), 32'h3);

    // R2: link clock period
    n = 0; rise0 = -1; rise1 = -1; prev = tx_lclk;
    while (rise1 < 0 && n < 100) begin
      @(negedge clk);
      n++;
      if (tx_lclk && !prev) begin
        if (rise0 < 0) rise0 = n; else rise1 = n;
      end
      prev = tx_lclk;
    end
    check(rise1 - rise0 == 2 * HALF, "R2 link period", rise1 - rise0, 2 * HALF);

    // receive vector table: R6 R7 R8 R9 R10
    foreach (VEC[k]) begin
      w  = VEC[k][23:0];
      ew = VEC[k][27] ? w : {8'h00, w[15:0]};
      pe = VEC[k][27] & VEC[k][26];
      fe = VEC[k][27] & ~VEC[k][25];
      c0 = got_cnt;
      rx_frame(VEC[k][27], w, VEC[k][26], VEC[k][25], 0);
      check(got_cnt == c0 + 1, "R10 one strobe", got_cnt - c0, 1);
      check(got_word == ew, VEC[k][27] ? "R6 long word" : "R7 short word", got_word, ew);
      check(got_pe == pe, "R8 parity flag", got_pe, pe);
      check(got_fe == fe, "R9 framing flag", got_fe, fe);
      rx_bit(1'b1);
      check(rx_word == ew, "R10 word holds", rx_word, ew);
    end

    // R9: after a missing stop, low bits are not start bits
    rx_frame(1'b1, 24'h5A5A5A, 1'b0, 1'b0, 0);
    c0 = got_cnt;
    check(got_fe == 1'b1 && got_word == 24'h5A5A5A, "R9 word with fault",
          got_word, 24'h5A5A5A);
    repeat (3) rx_bit(1'b0);
    check(got_cnt == c0, "R9 hunt no strobe", got_cnt - c0, 0);
    rx_bit(1'b1);
    rx_frame(1'b0, 24'h00C3A5, 1'b0, 1'b1, 0);
    check(got_cnt == c0 + 1 && got_word == 24'h00C3A5, "R9 resync word",
          got_word, 24'h00C3A5);
    rx_bit(1'b1);

    // R7: two short words back to back with no idle bit
    c0 = got_cnt;
    rx_frame(1'b0, 24'h00F00F, 1'b0, 1'b1, 0);
    check(got_word == 24'h00F00F, "R7 first back-to-back", got_word, 24'h00F00F);
    rx_frame(1'b0, 24'h000FF0, 1'b0, 1'b1, 0);
    check(got_cnt == c0 + 2 && got_word == 24'h000FF0, "R7 second back-to-back",
          got_word, 24'h000FF0);
    rx_bit(1'b1);

    // R11: format changes after the start bit
    rx_frame(1'b1, 24'h9ABCDE, 1'b0, 1'b1, 1);
    check(got_word == 24'h9ABCDE && !got_pe && !got_fe, "R11 long kept",
          got_word, 24'h9ABCDE);
    rx_bit(1'b1);
    c0 = got_cnt;
    rx_frame(1'b0, 24'h004321, 1'b0, 1'b1, 1);
    check(got_cnt == c0 + 1 && got_word == 24'h004321, "R11 short kept",
          got_word, 24'h004321);
    rx_fmt = 1'b1;
    repeat (30) rx_bit(1'b1);

    // transmit: R3 R4 R5
    tx_case(8'h3C, 16'h1234);
    tx_case(8'hFF, 16'hFFFF);
    tx_case(8'h00, 16'h0000);
    tx_case(8'h81, 16'h7E01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule